// File: doc/BRIEF.md
# Lookup-Table Logic Cell

This block is one configurable logic cell of a programmable fabric. Two 4-input lookup tables, called F and G, each hold a 16-bit truth table. A third 3-input table, H, combines the F result, the G result and one spare input. With these three tables the cell can implement two independent 4-input functions or one function of five inputs. For a 5-input function, F and G hold the two cofactors of the target and the spare input chooses between them.

Two output flip-flops, X and Y, each take their data from F, G, H or a direct data pin. Each flip-flop has its own clock enable and its own set/reset control. That control is configured per flip-flop to act as either set or reset. Each output pin shows either its flip-flop or a combinational generator result.

The F and G tables also work as writable 16x1 memories. When the write enable is high at a clock edge, the data pin is stored at the address formed by that table's four inputs. Reads are always combinational. Reset loads both tables from parameters and clears both flip-flops. The H table and all selections are static configuration inputs.

Top module: `clb_cell`

## Requirements
- R1: The F output equals bit `f_in` of the F table, and the G output equals bit `g_in` of the G table. Input bit 0 is the least significant address bit.
- R2: The H output equals bit `{h1_in, G, F}` of `cfg_h_tab`, with F as address bit 0, G as bit 1 and `h1_in` as bit 2.
- R3: With `cfg_h_tab` = 8'hCA and `f_in` equal to `g_in`, the H output realises a 5-input function. `h1_in` = 0 reads the F table and `h1_in` = 1 reads the G table.
- R4: When a register view is off, `x_out` shows H if `cfg_xcomb_h` is 1 and F otherwise. `y_out` shows H if `cfg_ycomb_h` is 1 and G otherwise.
- R5: Each flip-flop loads its source selected by `cfg_dsel_*`: 0 selects F, 1 selects G, 2 selects H and 3 selects `din`.
- R6: With its set/reset control low and its clock enable low, a flip-flop holds its value across a clock edge.
- R7: With its set/reset control high, a flip-flop loads 1 if `cfg_srset_*` is 1 and 0 otherwise, whatever its clock enable.
- R8: With `cfg_reg_x` (or `cfg_reg_y`) set, the output shows its flip-flop, and it changes in the cycle after the capturing edge.
- R9: When `we_f` (or `we_g`) is high at a clock edge, `din` is stored in that table at the address given by `f_in` (or `g_in`). The new value can be read right after that edge.
- R10: Reset (`rst_n` low, asynchronous) loads the tables from `F_INIT` and `G_INIT` and clears both flip-flops to 0.
- R11: While its write enable is low, a table keeps every bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| f_in | input | 4 | F table address inputs |
| g_in | input | 4 | G table address inputs |
| h1_in | input | 1 | Spare input to the H table |
| din | input | 1 | Direct data input and RAM write data |
| we_f | input | 1 | F table write enable |
| we_g | input | 1 | G table write enable |
| ce_x | input | 1 | X flip-flop clock enable |
| ce_y | input | 1 | Y flip-flop clock enable |
| sr_x | input | 1 | X flip-flop set/reset control |
| sr_y | input | 1 | Y flip-flop set/reset control |
| cfg_h_tab | input | 8 | H truth table |
| cfg_dsel_x | input | 2 | X flip-flop source: 0 F, 1 G, 2 H, 3 din |
| cfg_dsel_y | input | 2 | Y flip-flop source: 0 F, 1 G, 2 H, 3 din |
| cfg_srset_x | input | 1 | 1: sr_x sets the flip-flop, 0: sr_x clears it |
| cfg_srset_y | input | 1 | 1: sr_y sets the flip-flop, 0: sr_y clears it |
| cfg_reg_x | input | 1 | 1: x_out shows the flip-flop |
| cfg_reg_y | input | 1 | 1: y_out shows the flip-flop |
| cfg_xcomb_h | input | 1 | Combinational x_out shows H instead of F |
| cfg_ycomb_h | input | 1 | Combinational y_out shows H instead of G |
| x_out | output | 1 | X output |
| y_out | output | 1 | Y output |

## Verification
The hardest state to reach from the ports is a true 5-input function. It needs both tables rewritten through the memory path with the two cofactors of a chosen 32-bit target, with `f_in` and `g_in` tied together and H set to a 2:1 selector. The stimulus writes all 32 bits one address per cycle. It then sweeps all 32 input combinations and compares each against the target constant directly. Other phases give the set/reset controls a random pattern that overlaps the clock enable, so that priority is exercised in both set and reset modes.

// File: rtl/clb_pkg.sv
package clb_pkg;
    localparam int LUT_IN = 4;
    localparam int H_IN   = 3;
    localparam int N_FF   = 2;

    typedef enum logic [1:0] {
        SRC_F   = 2'd0,
        SRC_G   = 2'd1,
        SRC_H   = 2'd2,
        SRC_DIN = 2'd3
    } ff_src_e;

    typedef struct packed {
        logic f;
        logic g;
        logic h;
        logic din;
    } gen_vals_t;
endpackage

// File: rtl/clb_lut_ram.sv
module clb_lut_ram #(
    parameter int N_IN = 4,
    parameter logic [(2**N_IN)-1:0] INIT = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_IN-1:0] addr_i,
    input  logic            we_i,
    input  logic            wdata_i,
    output logic            rdata_o
);
    localparam int DEPTH = 2**N_IN;

    logic [DEPTH-1:0] tab_d, tab_q;

    always_comb begin
        tab_d = tab_q;
        if (we_i) begin
            tab_d[addr_i] = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tab_q <= INIT;
        end else begin
            tab_q <= tab_d;
        end
    end

    assign rdata_o = tab_q[addr_i];

    // R9: a write lands at the sampled address
    a_r9_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> tab_q[$past(addr_i)] == $past(wdata_i));

    // R11: no write leaves every bit unchanged
    a_r11_no_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(tab_q));
endmodule

// File: rtl/clb_hlut.sv
module clb_hlut #(
    parameter int N_SEL = 3
) (
    input  logic [(2**N_SEL)-1:0] tab_i,
    input  logic [N_SEL-1:0]      sel_i,
    output logic                  out_o
);
    always_comb begin
        out_o = tab_i[sel_i];
    end
endmodule

// File: rtl/clb_out_ff.sv
module clb_out_ff
    import clb_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  ff_src_e   src_i,
    input  gen_vals_t vals_i,
    input  logic      ce_i,
    input  logic      sr_i,
    input  logic      sr_set_i,
    output logic      q_o
);
    logic q_d, q_q;
    logic pick;

    always_comb begin
        unique case (src_i)
            SRC_F:   pick = vals_i.f;
            SRC_G:   pick = vals_i.g;
            SRC_H:   pick = vals_i.h;
            default: pick = vals_i.din;
        endcase
        q_d = q_q;
        if (sr_i) begin
            q_d = sr_set_i;
        end else if (ce_i) begin
            q_d = pick;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q <= 1'b0;
        end else begin
            q_q <= q_d;
        end
    end

    assign q_o = q_q;

    // R7: set/reset control wins over the clock enable
    a_r7_sr_set: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_i && sr_set_i) |=> q_o);
    a_r7_sr_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_i && !sr_set_i) |=> !q_o);
    // R6: disabled clock holds the value
    a_r6_ce_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!sr_i && !ce_i) |=> $stable(q_o));
endmodule

// File: rtl/clb_cell.sv
module clb_cell
    import clb_pkg::*;
#(
    parameter logic [(2**LUT_IN)-1:0] F_INIT = 16'h6996,
    parameter logic [(2**LUT_IN)-1:0] G_INIT = 16'h8000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  f_in,
    input  logic [3:0]  g_in,
    input  logic        h1_in,
    input  logic        din,
    input  logic        we_f,
    input  logic        we_g,
    input  logic        ce_x,
    input  logic        ce_y,
    input  logic        sr_x,
    input  logic        sr_y,
    input  logic [7:0]  cfg_h_tab,
    input  logic [1:0]  cfg_dsel_x,
    input  logic [1:0]  cfg_dsel_y,
    input  logic        cfg_srset_x,
    input  logic        cfg_srset_y,
    input  logic        cfg_reg_x,
    input  logic        cfg_reg_y,
    input  logic        cfg_xcomb_h,
    input  logic        cfg_ycomb_h,
    output logic        x_out,
    output logic        y_out
);
    logic      f_val, g_val, h_val;
    gen_vals_t vals;
    logic [N_FF-1:0] q_v, ce_v, sr_v, srset_v;
    ff_src_e   src_v [N_FF];

    clb_lut_ram #(.N_IN(LUT_IN), .INIT(F_INIT)) u_flut (
        .clk(clk), .rst_n(rst_n), .addr_i(f_in), .we_i(we_f),
        .wdata_i(din), .rdata_o(f_val)
    );

    clb_lut_ram #(.N_IN(LUT_IN), .INIT(G_INIT)) u_glut (
        .clk(clk), .rst_n(rst_n), .addr_i(g_in), .we_i(we_g),
        .wdata_i(din), .rdata_o(g_val)
    );

    clb_hlut #(.N_SEL(H_IN)) u_hlut (
        .tab_i(cfg_h_tab), .sel_i({h1_in, g_val, f_val}), .out_o(h_val)
    );

    always_comb begin
        vals.f   = f_val;
        vals.g   = g_val;
        vals.h   = h_val;
        vals.din = din;
    end

    assign ce_v    = {ce_y, ce_x};
    assign sr_v    = {sr_y, sr_x};
    assign srset_v = {cfg_srset_y, cfg_srset_x};
    assign src_v[0] = ff_src_e'(cfg_dsel_x);
    assign src_v[1] = ff_src_e'(cfg_dsel_y);

    for (genvar i = 0; i < N_FF; i++) begin : g_ff
        clb_out_ff u_ff (
            .clk(clk), .rst_n(rst_n), .src_i(src_v[i]), .vals_i(vals),
            .ce_i(ce_v[i]), .sr_i(sr_v[i]), .sr_set_i(srset_v[i]),
            .q_o(q_v[i])
        );
    end

    always_comb begin
        if (cfg_reg_x) x_out = q_v[0];
        else           x_out = cfg_xcomb_h ? h_val : f_val;
        if (cfg_reg_y) y_out = q_v[1];
        else           y_out = cfg_ycomb_h ? h_val : g_val;
    end

    // R8: with the register view on and the flip-flop idle, x_out holds
    a_r8_x_reg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_reg_x && !sr_x && !ce_x) |=> (!cfg_reg_x || $stable(x_out)));
    a_r8_y_reg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_reg_y && !sr_y && !ce_y) |=> (!cfg_reg_y || $stable(y_out)));
endmodule

// File: tb/clb_cell_tb.sv
module clb_cell_tb_top;
    localparam logic [15:0] FI = 16'hB3D1;
    localparam logic [15:0] GI = 16'h7E24;
    localparam logic [31:0] TGT = 32'hA5C3_1E97;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0] f_in = '0, g_in = '0;
    logic h1_in = 0, din = 0, we_f = 0, we_g = 0;
    logic ce_x = 0, ce_y = 0, sr_x = 0, sr_y = 0;
    logic [7:0] cfg_h_tab = '0;
    logic [1:0] cfg_dsel_x = '0, cfg_dsel_y = '0;
    logic cfg_srset_x = 0, cfg_srset_y = 0, cfg_reg_x = 0, cfg_reg_y = 0;
    logic cfg_xcomb_h = 0, cfg_ycomb_h = 0;
    logic x_out, y_out;

    int n_chk = 0, n_fail = 0;
    bit [15:0] mf, mg;
    bit mxq, myq;
    logic [31:0] rng = 32'h1234_5678;

    always #5 clk = ~clk;

    clb_cell #(.F_INIT(FI), .G_INIT(GI)) dut_i (.*);

    function automatic logic [31:0] nxt(logic [31:0] s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    function automatic bit src_val(logic [1:0] sel, bit fv, bit gv, bit hv, bit dv);
        case (sel)
            2'd0: return fv;
            2'd1: return gv;
            2'd2: return hv;
            default: return dv;
        endcase
    endfunction

    task automatic chk(string tag, logic act, bit exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // compare at the current point, then advance one cycle and update the model
    task automatic cyc(string tag);
        bit fv, gv, hv;
        #1;
        fv = mf[f_in]; gv = mg[g_in]; hv = cfg_h_tab[{h1_in, gv, fv}];
        chk(tag, x_out, cfg_reg_x ? mxq : (cfg_xcomb_h ? hv : fv));
        chk(tag, y_out, cfg_reg_y ? myq : (cfg_ycomb_h ? hv : gv));
        @(posedge clk);
        if (rst_n) begin
            if (sr_x) mxq = cfg_srset_x; else if (ce_x) mxq = src_val(cfg_dsel_x, fv, gv, hv, din);
            if (sr_y) myq = cfg_srset_y; else if (ce_y) myq = src_val(cfg_dsel_y, fv, gv, hv, din);
            if (we_f) mf[f_in] = din;
            if (we_g) mg[g_in] = din;
        end else begin
            mf = FI; mg = GI; mxq = 0; myq = 0;
        end
        @(negedge clk);
    endtask

    task automatic rnd_in();
        rng = nxt(rng); f_in = rng[3:0]; g_in = rng[7:4]; h1_in = rng[8]; din = rng[9];
    endtask

    initial begin
        #200000;
        n_fail++; n_chk++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        mf = FI; mg = GI; mxq = 0; myq = 0;
        @(negedge clk); @(negedge clk);
        // R10: reset state, registers cleared
        cfg_reg_x = 1; cfg_reg_y = 1;
        #1; chk("R10 x reg", x_out, 1'b0); chk("R10 y reg", y_out, 1'b0);
        @(negedge clk);
        rst_n = 1;
        cfg_reg_x = 0; cfg_reg_y = 0;
        // R1 R10: tables read their initial contents
        for (int i = 0; i < 16; i++) begin
            f_in = i[3:0]; g_in = 4'(15 - i);
            #1; chk("R10 F init", x_out, FI[i]); chk("R10 G init", y_out, GI[15-i]);
            cyc("R1 R10");
        end
        // R2 R4: H path on both outputs
        cfg_xcomb_h = 1; cfg_ycomb_h = 1;
        for (int i = 0; i < 40; i++) begin
            rng = nxt(rng); cfg_h_tab = rng[17:10]; rnd_in(); cyc("R2 R4");
        end
        cfg_ycomb_h = 0;
        for (int i = 0; i < 20; i++) begin rnd_in(); cyc("R4"); end
        // R5 R6 R8: register sources and clock enable
        cfg_reg_x = 1; cfg_reg_y = 1;
        for (int i = 0; i < 80; i++) begin
            rnd_in(); rng = nxt(rng);
            cfg_dsel_x = rng[1:0]; cfg_dsel_y = rng[3:2];
            ce_x = rng[4]; ce_y = rng[5]; cfg_h_tab = rng[15:8];
            cyc("R5 R6 R8");
        end
        // R7: set/reset over clock enable, both modes
        for (int i = 0; i < 80; i++) begin
            rnd_in(); rng = nxt(rng);
            sr_x = rng[0]; sr_y = rng[1]; ce_x = rng[2]; ce_y = rng[3];
            cfg_srset_x = rng[4]; cfg_srset_y = rng[5]; cfg_dsel_x = rng[7:6];
            cyc("R7");
        end
        sr_x = 0; sr_y = 0; ce_x = 0; ce_y = 0;
        cfg_reg_x = 0; cfg_reg_y = 0; cfg_xcomb_h = 0;
        // R9 R11: RAM writes mixed with idle cycles
        for (int i = 0; i < 120; i++) begin
            rnd_in(); rng = nxt(rng); we_f = rng[0] & rng[1]; we_g = rng[2] & rng[3];
            cyc("R9 R11");
        end
        we_f = 0; we_g = 0;
        // R3: load cofactors of the 5-input target, then sweep it
        for (int i = 0; i < 16; i++) begin
            f_in = i[3:0]; g_in = i[3:0]; din = TGT[i]; we_f = 1; cyc("R9");
            we_f = 0; din = TGT[16+i]; we_g = 1; cyc("R9"); we_g = 0;
        end
        cfg_h_tab = 8'hCA; cfg_xcomb_h = 1;
        for (int i = 0; i < 32; i++) begin
            f_in = i[3:0]; g_in = i[3:0]; h1_in = i[4];
            #1; chk("R3 five-input", x_out, TGT[i]);
            cyc("R3");
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule